// File: doc/BRIEF.md
# Up/Down 16-bit Counter/Timer

This block is a 16-bit counter/timer whose count is reached through a small byte-wide register bus, as two bytes at separate addresses. In timer mode it advances on ticks from a prescaler. The prescaler divides the system clock by 1, 2 or 12, or divides rising edges of a slow external oscillator input by 8. In counter mode it advances once for each high-to-low transition on an external count pin. Every pin input passes through a two-flop synchronizer before any edge is detected.

Two modes decide what happens when the count wraps. In auto-reload mode an overflow loads a 16-bit reload value. In capture mode the count wraps freely, and a falling edge on an auxiliary pin copies the count into a capture register. A decrement-enable bit can give the auxiliary pin a different job: it then sets the count direction (high counts up, low counts down) and can no longer trigger a capture. A toggle-enable bit makes an output pin invert on every overflow or underflow, which turns the block into a square-wave generator.

A three-state machine sequences the block: ST_IDLE, ST_TIMER and ST_EVENT. It goes from ST_IDLE to ST_TIMER or ST_EVENT when the run bit is set, choosing by the source-select bit. It moves between ST_TIMER and ST_EVENT when the source-select bit changes while running. It returns to ST_IDLE from either running state when the run bit clears. Each move takes effect one clock after the register write that causes it.

Top module: `updn_timer16`

## Requirements
- R1: After reset, all eight registers read 0 and the flag and toggle outputs are 0.
- R2: The register map is as follows. Address 0 is control: bit0 run, bit1 source select (1 = count pin edges), bit2 capture mode (0 = auto-reload), bit3 overflow flag, bit4 capture flag. Address 1 is configuration: bits[1:0] clock select, bit2 decrement enable, bit3 toggle enable. Addresses 2 and 3 are the count low and high byte. Addresses 4 and 5 are the reload low and high byte. Addresses 6 and 7 are the capture low and high byte, read-only. Unused bits read 0.
- R3: A bus write to either count byte lands at the write's clock edge and takes precedence over a count step in that same cycle.
- R4: In timer mode the clock select works as follows: 0 steps every cycle, 1 every 2 cycles, 2 every 12 cycles, and 3 on every 8th rising edge of the external oscillator input. The first step comes one full divide period after the block enters ST_TIMER.
- R5: In counter mode each falling edge on the count pin steps the count once.
- R6: With run at 0 the count holds, and the prescaler restarts from zero.
- R7: In auto-reload mode, an up step from 0xFFFF loads the reload value and sets the overflow flag.
- R8: When decrement enable is 1, a high auxiliary pin counts up and a low one counts down. A down step from the reload value (auto-reload mode), or from 0 (capture mode), gives 0xFFFF and sets the overflow flag.
- R9: In capture mode with decrement enable at 0, a falling edge on the auxiliary pin copies the count into the capture register and sets the capture flag, and the count is left untouched. An up step from 0xFFFF gives 0 and sets the overflow flag.
- R10: When decrement enable is 1, a falling edge on the auxiliary pin captures nothing and does not set the capture flag.
- R11: With toggle enable set, the toggle output inverts on each overflow or underflow.
- R12: Flags stay set until a control write puts 0 in their bit. Writing 1 to a flag bit leaves it as it is. A hardware set wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cnt_pin | input | 1 | External count input, falling edges counted |
| aux_pin | input | 1 | Capture trigger, or direction when decrement enable is 1 |
| ext_osc | input | 1 | Slow external oscillator for the divide-by-8 choice |
| ovf_flag | output | 1 | Sticky overflow/underflow flag |
| cap_flag | output | 1 | Sticky capture flag |
| tgl_out | output | 1 | Square-wave toggle output |

## Verification
The bench times each prescaler choice from the moment the block starts running. A divider that is off by one would give a count too large or too small. So would a prescaler that carries over its old phase and so does not restart. It drives the count through the 0xFFFF wrap in auto-reload mode and through both wrap cases in capture mode. It also drives down-count underflow at the reload value and at zero. A design that reloaded or wrapped to the wrong value, or that skipped the flag or the toggle, shows up as a wrong count byte or pin level.

It writes a count byte while the timer runs every cycle. A design that let the count step win would read one higher. It pulses the auxiliary pin while decrement enable is set. A design that captured anyway would set the capture flag. Flag bits are written back both as 1 and as 0, which catches a design that clears on any write.

// File: rtl/ut16_pkg.sv
package ut16_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TIMER = 2'd1,
        ST_EVENT = 2'd2
    } ut_state_e;

    typedef enum logic [1:0] {
        CK_DIV1  = 2'd0,
        CK_DIV2  = 2'd1,
        CK_DIV12 = 2'd2,
        CK_EXT8  = 2'd3
    } ut_clksel_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_CFG    = 3'd1;
    localparam logic [2:0] A_CNT_LO = 3'd2;
    localparam logic [2:0] A_CNT_HI = 3'd3;
    localparam logic [2:0] A_RLD_LO = 3'd4;
    localparam logic [2:0] A_RLD_HI = 3'd5;
    localparam logic [2:0] A_CAP_LO = 3'd6;
    localparam logic [2:0] A_CAP_HI = 3'd7;
endpackage

// File: rtl/ut16_sync_edge.sv
module ut16_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic lvl_dly
);
    logic [STAGES-1:0] chain_q;
    logic              dly_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[gi] <= 1'b0;
                end else begin
                    chain_q[gi] <= (gi == 0) ? pin : chain_q[(gi == 0) ? 0 : gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= 1'b0;
        else        dly_q <= chain_q[STAGES-1];
    end

    assign lvl     = chain_q[STAGES-1];
    assign lvl_dly = dly_q;
endmodule

// File: rtl/ut16_prescaler.sv
module ut16_prescaler
    import ut16_pkg::*;
#(
    parameter int DIV_B   = 2,
    parameter int DIV_C   = 12,
    parameter int DIV_EXT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  ut_clksel_e sel,
    input  logic       ext_rise,
    output logic       tick
);
    localparam int MAX_AB = (DIV_B > DIV_C) ? DIV_B : DIV_C;
    localparam int MAX_D  = (MAX_AB > DIV_EXT) ? MAX_AB : DIV_EXT;
    localparam int PW     = (MAX_D > 2) ? $clog2(MAX_D) : 1;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] last;
    logic          adv;

    always_comb begin
        unique case (sel)
            CK_DIV1:  last = '0;
            CK_DIV2:  last = PW'(DIV_B - 1);
            CK_DIV12: last = PW'(DIV_C - 1);
            CK_EXT8:  last = PW'(DIV_EXT - 1);
        endcase
        adv  = (sel == CK_EXT8) ? ext_rise : 1'b1;
        tick = active && adv && (cnt_q == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/updn_timer16.sv
module updn_timer16
    import ut16_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int SYNC_STG  = 2,
    parameter int DIV_B     = 2,
    parameter int DIV_C     = 12,
    parameter int DIV_EXT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cnt_pin,
    input  logic              aux_pin,
    input  logic              ext_osc,
    output logic              ovf_flag,
    output logic              cap_flag,
    output logic              tgl_out
);
    localparam int CW = 2 * BYTE_W;
    localparam logic [CW-1:0] CNT_MAX = '1;

    ut_state_e   state_q, state_d;
    logic        run_q, src_q, capm_q, ovf_q, capf_q;
    ut_clksel_e  cksel_q;
    logic        dec_q, tgle_q, tgl_q;
    logic [CW-1:0] cnt_q, cnt_nx, rld_q, cap_q, bottom;
    logic        cnt_s, cnt_d, aux_s, aux_d, ext_s, ext_d;
    logic        cnt_fall, aux_fall, ext_rise, tick, step, dir_up, evt;
    logic        wr_ctrl, wr_cfg, wr_clo, wr_chi, cap_trig;

    ut16_sync_edge #(.STAGES(SYNC_STG)) u_sync_cnt (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .lvl(cnt_s), .lvl_dly(cnt_d));
    ut16_sync_edge #(.STAGES(SYNC_STG)) u_sync_aux (
        .clk(clk), .rst_n(rst_n), .pin(aux_pin), .lvl(aux_s), .lvl_dly(aux_d));
    ut16_sync_edge #(.STAGES(SYNC_STG)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_osc), .lvl(ext_s), .lvl_dly(ext_d));

    assign cnt_fall = cnt_d & ~cnt_s;
    assign aux_fall = aux_d & ~aux_s;
    assign ext_rise = ext_s & ~ext_d;

    ut16_prescaler #(.DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_EXT(DIV_EXT)) u_pre (
        .clk(clk), .rst_n(rst_n), .active(state_q == ST_TIMER),
        .sel(cksel_q), .ext_rise(ext_rise), .tick(tick));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_q) state_d = src_q ? ST_EVENT : ST_TIMER;
            ST_TIMER: if (!run_q) state_d = ST_IDLE;
                      else if (src_q) state_d = ST_EVENT;
            ST_EVENT: if (!run_q) state_d = ST_IDLE;
                      else if (!src_q) state_d = ST_TIMER;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output process: step, direction, wrap handling
    always_comb begin
        step   = ((state_q == ST_TIMER) && tick) || ((state_q == ST_EVENT) && cnt_fall);
        dir_up = !dec_q || aux_s;
        bottom = capm_q ? '0 : rld_q;
        evt    = 1'b0;
        cnt_nx = cnt_q;
        if (step) begin
            if (dir_up) begin
                if (cnt_q == CNT_MAX) begin
                    evt    = 1'b1;
                    cnt_nx = capm_q ? '0 : rld_q;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == bottom) begin
                    evt    = 1'b1;
                    cnt_nx = CNT_MAX;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
        end
    end

    assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
    assign wr_cfg   = bus_we && (bus_addr == A_CFG);
    assign wr_clo   = bus_we && (bus_addr == A_CNT_LO);
    assign wr_chi   = bus_we && (bus_addr == A_CNT_HI);
    assign cap_trig = capm_q && !dec_q && aux_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0; src_q <= 1'b0; capm_q <= 1'b0;
            ovf_q <= 1'b0; capf_q <= 1'b0; tgl_q <= 1'b0;
            cksel_q <= CK_DIV1; dec_q <= 1'b0; tgle_q <= 1'b0;
            cnt_q <= '0; rld_q <= '0; cap_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= bus_wdata[0];
                src_q  <= bus_wdata[1];
                capm_q <= bus_wdata[2];
            end
            if (wr_cfg) begin
                cksel_q <= ut_clksel_e'(bus_wdata[1:0]);
                dec_q   <= bus_wdata[2];
                tgle_q  <= bus_wdata[3];
            end
            if (bus_we && (bus_addr == A_RLD_LO)) rld_q[BYTE_W-1:0]  <= bus_wdata;
            if (bus_we && (bus_addr == A_RLD_HI)) rld_q[CW-1:BYTE_W] <= bus_wdata;
            if (wr_clo) cnt_q[BYTE_W-1:0]  <= bus_wdata;
            if (wr_chi) cnt_q[CW-1:BYTE_W] <= bus_wdata;
            if (!(wr_clo || wr_chi)) cnt_q <= cnt_nx;
            if (cap_trig) cap_q <= cnt_q;
            ovf_q  <= evt      | (wr_ctrl ? (ovf_q  & bus_wdata[3]) : ovf_q);
            capf_q <= cap_trig | (wr_ctrl ? (capf_q & bus_wdata[4]) : capf_q);
            if (evt && tgle_q) tgl_q <= ~tgl_q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata[4:0] = {capf_q, ovf_q, capm_q, src_q, run_q};
            A_CFG:    bus_rdata[3:0] = {tgle_q, dec_q, cksel_q};
            A_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = cnt_q[CW-1:BYTE_W];
            A_RLD_LO: bus_rdata = rld_q[BYTE_W-1:0];
            A_RLD_HI: bus_rdata = rld_q[CW-1:BYTE_W];
            A_CAP_LO: bus_rdata = cap_q[BYTE_W-1:0];
            A_CAP_HI: bus_rdata = cap_q[CW-1:BYTE_W];
            default:  bus_rdata = '0;
        endcase
    end

    assign ovf_flag = ovf_q;
    assign cap_flag = capf_q;
    assign tgl_out  = tgl_q;
endmodule

// File: rtl/ut16_checker.sv
module ut16_checker
    import ut16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input ut_state_e   state,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [15:0] cnt,
    input logic        evt,
    input logic        tgl_en,
    input logic        dec_en,
    input logic        tgl_out,
    input logic        ovf_flag,
    input logic        cap_flag
);
    AST_CNT_LO_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CNT_LO) |=> (cnt[7:0] == $past(bus_wdata))); // R3

    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(bus_we && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI)))
        |=> $stable(cnt)); // R6

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> ovf_flag); // R7

    AST_NO_CAPTURE_WHEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !cap_flag) |=> !cap_flag); // R10

    AST_TOGGLE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && tgl_en) |=> (tgl_out != $past(tgl_out))); // R11

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(bus_we && bus_addr == A_CTRL && !bus_wdata[3])) |=> ovf_flag); // R12
endmodule

bind updn_timer16 ut16_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q), .evt(evt),
    .tgl_en(tgle_q), .dec_en(dec_q), .tgl_out(tgl_out),
    .ovf_flag(ovf_flag), .cap_flag(cap_flag));

// File: tb/tb_updn_timer16.sv
`timescale 1ns/1ps
module tb_updn_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_pin = 1'b1;
    logic       aux_pin = 1'b1;
    logic       ext_osc = 1'b0;
    logic       ovf_flag, cap_flag, tgl_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] exp_val_q[$];
    string      exp_tag_q[$];

    always #5 clk = ~clk;

    updn_timer16 dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
        .aux_pin(aux_pin), .ext_osc(ext_osc), .ovf_flag(ovf_flag),
        .cap_flag(cap_flag), .tgl_out(tgl_out));

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items and compares with the read bus
    always @(negedge clk) begin
        if (exp_val_q.size() > 0) begin
            automatic logic [7:0] e = exp_val_q.pop_front();
            automatic string t = exp_tag_q.pop_front();
            check(t, {8'h00, bus_rdata}, {8'h00, e});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        exp_val_q.push_back(e);
        exp_tag_q.push_back(tag);
        @(negedge clk); #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        peek(a, e, tag);
    endtask

    task automatic cnt_edge();
        cnt_pin = 1'b0;
        repeat (4) @(posedge clk);
        cnt_pin = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic set_count(input logic [15:0] v);
        wr(3'd2, v[7:0]);
        wr(3'd3, v[15:8]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 8; i++) rd(3'(i), 8'h00, "R1 reset reg");
        check("R1 tgl_out", {15'd0, tgl_out}, 16'd0);
        check("R1 ovf_flag", {15'd0, ovf_flag}, 16'd0);

        // R2 register map
        wr(3'd4, 8'h34); wr(3'd5, 8'h12);
        rd(3'd4, 8'h34, "R2 reload lo");
        rd(3'd5, 8'h12, "R2 reload hi");
        set_count(16'hABCD);
        rd(3'd2, 8'hCD, "R2 count lo");
        rd(3'd3, 8'hAB, "R2 count hi");
        wr(3'd1, 8'h0E);
        rd(3'd1, 8'h0E, "R2 cfg readback");

        // R4 divide by 1
        set_count(16'h0000);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h01);
        repeat (9) @(posedge clk);
        rd(3'd2, 8'h09, "R4 div1 count");
        wr(3'd0, 8'h00);
        rd(3'd2, 8'h0C, "R6 stop holds count");
        repeat (20) @(posedge clk);
        rd(3'd2, 8'h0C, "R6 still held");

        // R3 write beats count step
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h55);
        peek(3'd2, 8'h55, "R3 write wins");
        wr(3'd0, 8'h00);

        // R4 divide by 2
        set_count(16'h0000);
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h01);
        repeat (9) @(posedge clk);
        rd(3'd2, 8'h04, "R4 div2 count");
        wr(3'd0, 8'h00);

        // R4 divide by 12
        set_count(16'h0000);
        wr(3'd1, 8'h02);
        wr(3'd0, 8'h01);
        repeat (25) @(posedge clk);
        rd(3'd2, 8'h02, "R4 div12 count");
        wr(3'd0, 8'h00);

        // R4 external oscillator divide by 8
        set_count(16'h0000);
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h01);
        for (int i = 0; i < 20; i++) begin
            ext_osc = 1'b1; repeat (2) @(posedge clk);
            ext_osc = 1'b0; repeat (2) @(posedge clk);
        end
        repeat (8) @(posedge clk);
        wr(3'd0, 8'h00);
        rd(3'd2, 8'h02, "R4 ext8 count");

        // R5 counter mode, R7 reload, R11 toggle
        wr(3'd1, 8'h08);
        set_count(16'hFFFD);
        wr(3'd0, 8'h03);
        cnt_edge(); cnt_edge();
        rd(3'd2, 8'hFF, "R5 count lo after edges");
        rd(3'd3, 8'hFF, "R5 count hi after edges");
        check("R7 no flag before wrap", {15'd0, ovf_flag}, 16'd0);
        cnt_edge();
        rd(3'd2, 8'h34, "R7 reload lo");
        rd(3'd3, 8'h12, "R7 reload hi");
        rd(3'd0, 8'h0B, "R7 overflow flag bit");
        check("R11 toggle high", {15'd0, tgl_out}, 16'd1);
        cnt_edge();
        rd(3'd2, 8'h35, "R5 continues after reload");

        // R12 flag write behaviour
        wr(3'd0, 8'h0B);
        check("R12 write 1 keeps", {15'd0, ovf_flag}, 16'd1);
        wr(3'd0, 8'h03);
        check("R12 write 0 clears", {15'd0, ovf_flag}, 16'd0);

        // R8 down counting in reload mode
        wr(3'd1, 8'h0C);
        aux_pin = 1'b0;
        repeat (4) @(posedge clk);
        cnt_edge();
        rd(3'd2, 8'h34, "R8 down step");
        check("R8 no flag at reload value", {15'd0, ovf_flag}, 16'd0);
        cnt_edge();
        rd(3'd2, 8'hFF, "R8 underflow lo");
        rd(3'd3, 8'hFF, "R8 underflow hi");
        check("R8 underflow flag", {15'd0, ovf_flag}, 16'd1);
        check("R11 toggle low", {15'd0, tgl_out}, 16'd0);
        aux_pin = 1'b1;
        repeat (4) @(posedge clk);
        cnt_edge();
        rd(3'd3, 8'h12, "R8 aux high counts up");

        // R10 no capture while decrement enabled
        wr(3'd0, 8'h04);
        aux_pin = 1'b0;
        repeat (6) @(posedge clk);
        aux_pin = 1'b1;
        repeat (6) @(posedge clk);
        aux_pin = 1'b0;
        repeat (6) @(posedge clk);
        check("R10 cap flag stays 0", {15'd0, cap_flag}, 16'd0);
        rd(3'd6, 8'h00, "R10 capture reg untouched");

        // R9 capture
        wr(3'd1, 8'h00);
        aux_pin = 1'b1;
        set_count(16'h0ABC);
        repeat (4) @(posedge clk);
        aux_pin = 1'b0;
        repeat (6) @(posedge clk);
        rd(3'd6, 8'hBC, "R9 capture lo");
        rd(3'd7, 8'h0A, "R9 capture hi");
        rd(3'd0, 8'h14, "R9 capture flag bit");
        rd(3'd2, 8'hBC, "R9 count untouched");

        // R9 free wrap in capture mode
        set_count(16'hFFFF);
        wr(3'd0, 8'h17);
        cnt_edge();
        rd(3'd2, 8'h00, "R9 wrap lo");
        rd(3'd3, 8'h00, "R9 wrap hi");
        check("R9 wrap flag", {15'd0, ovf_flag}, 16'd1);

        // R8 down from zero in capture mode
        wr(3'd0, 8'h17);
        wr(3'd1, 8'h04);
        repeat (4) @(posedge clk);
        cnt_edge();
        rd(3'd3, 8'hFF, "R8 capture mode underflow");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule